// File: doc/BRIEF.md
# Dual-Channel Output Port Controller

This block drives one egress port of a packet switch. Two upstream switch sources each hand it retrieve addresses through a small per-source address queue. When the port sequencer pulses a grant, the controller takes up to two queued addresses. It fetches the packets they point to from packet memory, one after the other, and presents them together as a pair: the first on a high channel and the second on a low channel. If only one address is waiting, the low channel is marked idle.

The controller merges the two sources onto the one port. When both queues hold addresses, it alternates between them. When only one does, it drains that one. Within a source, addresses leave in arrival order. Before the pair is offered, the controller writes the current ingress and subport flow-control grant bits into an 8-bit field at the bottom of each packet's header word. The pair is held on a valid/ready output until the serializer side accepts it.

The memory is reached through a single-outstanding read request and an in-order response strobe.

Top module: `dual_chan_port_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `o_valid` and `rd_req` are 0 and both `*_full` flags are 0.
- R2: A `seq_grant` pulse that arrives while the controller is idle and both queues are empty is ignored. No read is issued and `o_valid` stays 0.
- R3: A grant taken with two or more addresses pending fetches two packets. The high channel carries the packet at the first address selected and the low channel carries the packet at the second, with `o_lo_idle` = 0.
- R4: A grant taken with exactly one address pending sends that packet on the high channel. It sets `o_lo_idle` = 1 and `o_lo_word` = 0, and issues one read only.
- R5: Source selection applies for each packet slot in turn. With both queues non-empty, the source opposite to the last one taken is used; otherwise the non-empty source is used. After reset the first tie goes to source A. The source ids on `o_hi_src`/`o_lo_src` are 0 = A and 1 = B. Each source is served first in, first out.
- R6: In every non-idle output word, bits [7:4] equal `fc_ingress` and bits [3:0] equal `fc_subport`, as sampled at the clock edge where `o_valid` rises. Bits above 7 are the memory data unchanged.
- R7: While `o_valid` = 1 and `o_ready` = 0, every output word and flag holds its value, whatever the grant-bit inputs do.
- R8: A queue holding DEPTH (default 4) addresses raises its `*_full` flag. A push into it on such a cycle is dropped.
- R9: `seq_grant` pulses that arrive while a pair is being fetched or offered have no effect on the queues or the output.
- R10: Reads use one-cycle `rd_req` pulses with at most one outstanding, the high-channel address first. No read is issued while `o_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_push | input | 1 | Source A address strobe |
| a_addr | input | AW | Source A retrieve address |
| b_push | input | 1 | Source B address strobe |
| b_addr | input | AW | Source B retrieve address |
| a_full | output | 1 | Source A queue full |
| b_full | output | 1 | Source B queue full |
| seq_grant | input | 1 | Access grant pulse from the port sequencer |
| fc_ingress | input | GW | Ingress flow-control grant bits |
| fc_subport | input | GW | Subport flow-control grant bits |
| rd_req | output | 1 | Memory read request pulse |
| rd_addr | output | AW | Memory read address |
| rd_rvalid | input | 1 | Read data strobe |
| rd_rdata | input | DW | Read data (header word) |
| o_valid | output | 1 | Pair valid |
| o_ready | input | 1 | Pair accepted when high with o_valid |
| o_hi_word | output | DW | High-channel header word |
| o_lo_word | output | DW | Low-channel header word |
| o_lo_idle | output | 1 | Low channel carries no packet |
| o_hi_src | output | 1 | Source of high-channel packet |
| o_lo_src | output | 1 | Source of low-channel packet |

## Verification
The grant that pops addresses can land in the same cycle as a push into the same queue. The queue must then take the new address behind the ones leaving, and judge fullness on the count before the pop. The bench provokes this directly with a grant pulse that carries pushes on one or both sources. It also mixes such pulses into the random phase. Each case is judged by comparing the source, address data and channel of every later pair against a bench queue model, which applies the pop before the push.

// File: rtl/dual_chan_port_ctrl.sv
module dual_chan_port_ctrl #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int GW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_push,
  input  logic [AW-1:0] a_addr,
  input  logic          b_push,
  input  logic [AW-1:0] b_addr,
  output logic          a_full,
  output logic          b_full,
  input  logic          seq_grant,
  input  logic [GW-1:0] fc_ingress,
  input  logic [GW-1:0] fc_subport,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_rvalid,
  input  logic [DW-1:0] rd_rdata,
  output logic          o_valid,
  input  logic          o_ready,
  output logic [DW-1:0] o_hi_word,
  output logic [DW-1:0] o_lo_word,
  output logic          o_lo_idle,
  output logic          o_hi_src,
  output logic          o_lo_src
);
  localparam int HW = 2 * GW;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {IDLE, REQ, WAIT, OUT} state_t;
  state_t st;

  logic [AW-1:0] q    [2][DEPTH];
  logic [PW-1:0] wp   [2];
  logic [PW-1:0] rp   [2];
  logic [CW-1:0] cnt  [2];
  logic [1:0]    push, full, push_ok;
  logic [1:0]    pop_n [2];
  logic [AW-1:0] in_addr [2];

  logic          last_b, chan, lo_used;
  logic [AW-1:0] hi_a, lo_a;
  logic [DW-1:0] hw, lw;
  logic [HW-1:0] gbits;

  assign push       = {b_push, a_push};
  assign in_addr[0] = a_addr;
  assign in_addr[1] = b_addr;
  assign gbits      = {fc_ingress, fc_subport};

  for (genvar s = 0; s < 2; s++) begin : g_q
    assign full[s]    = (cnt[s] == CW'(DEPTH));
    assign push_ok[s] = push[s] && !full[s];
  end
  assign a_full = full[0];
  assign b_full = full[1];

  logic          p1_ok, p1_b, p2_ok, p2_b, take;
  logic [CW-1:0] ca2, cb2;

  assign p1_ok = (cnt[0] != 0) || (cnt[1] != 0);
  assign p1_b  = ((cnt[0] != 0) && (cnt[1] != 0)) ? !last_b : (cnt[1] != 0);
  assign ca2   = cnt[0] - CW'(p1_ok && !p1_b);
  assign cb2   = cnt[1] - CW'(p1_ok && p1_b);
  assign p2_ok = (ca2 != 0) || (cb2 != 0);
  assign p2_b  = ((ca2 != 0) && (cb2 != 0)) ? !p1_b : (cb2 != 0);
  assign take  = (st == IDLE) && seq_grant && p1_ok;

  always_comb begin
    pop_n[0] = '0;
    pop_n[1] = '0;
    if (take) begin
      pop_n[p1_b] = 2'd1;
      if (p2_ok) pop_n[p2_b] = pop_n[p2_b] + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < 2; s++)
      if (push_ok[s]) q[s][wp[s]] <= in_addr[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin
        wp[s]  <= '0;
        rp[s]  <= '0;
        cnt[s] <= '0;
      end
    end else begin
      for (int s = 0; s < 2; s++) begin
        if (push_ok[s]) wp[s] <= wp[s] + PW'(1);
        rp[s]  <= rp[s] + PW'(pop_n[s]);
        cnt[s] <= cnt[s] + CW'(push_ok[s]) - CW'(pop_n[s]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      last_b   <= 1'b1;
      chan     <= 1'b0;
      lo_used  <= 1'b0;
      hi_a     <= '0;
      lo_a     <= '0;
      o_hi_src <= 1'b0;
      o_lo_src <= 1'b0;
      hw       <= '0;
      lw       <= '0;
    end else begin
      case (st)
        IDLE: if (take) begin
          hi_a     <= q[p1_b][rp[p1_b]];
          lo_a     <= q[p2_b][rp[p2_b] + PW'(p1_b == p2_b)];
          o_hi_src <= p1_b;
          o_lo_src <= p2_ok ? p2_b : 1'b0;
          lo_used  <= p2_ok;
          last_b   <= p2_ok ? p2_b : p1_b;
          chan     <= 1'b0;
          st       <= REQ;
        end
        REQ: st <= WAIT;
        WAIT: if (rd_rvalid) begin
          if (!chan) begin
            if (lo_used) begin
              hw   <= rd_rdata;
              chan <= 1'b1;
              st   <= REQ;
            end else begin
              hw <= {rd_rdata[DW-1:HW], gbits};
              lw <= '0;
              st <= OUT;
            end
          end else begin
            hw <= {hw[DW-1:HW], gbits};
            lw <= {rd_rdata[DW-1:HW], gbits};
            st <= OUT;
          end
        end
        OUT: if (o_ready) begin
          chan <= 1'b0;
          st   <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign rd_req    = (st == REQ);
  assign rd_addr   = chan ? lo_a : hi_a;
  assign o_valid   = (st == OUT);
  assign o_hi_word = hw;
  assign o_lo_word = lw;
  assign o_lo_idle = !lo_used;
endmodule

// File: rtl/dual_chan_port_ctrl_chk.sv
module dual_chan_port_ctrl_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_push,
  input logic          a_full,
  input logic          seq_grant,
  input logic          rd_req,
  input logic          o_valid,
  input logic          o_ready,
  input logic [DW-1:0] o_hi_word,
  input logic [DW-1:0] o_lo_word,
  input logic          o_lo_idle,
  input logic          o_hi_src,
  input logic          o_lo_src
);
  p_rst_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !o_valid && !rd_req);

  p_hold_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_ready |=> o_valid && $stable(o_hi_word) && $stable(o_lo_word)
      && $stable(o_lo_idle) && $stable(o_hi_src) && $stable(o_lo_src));

  p_idle_lo_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && o_lo_idle |-> o_lo_word == '0);

  p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  p_no_req_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> !rd_req);

  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    a_full && a_push && !seq_grant |=> a_full);
endmodule

bind dual_chan_port_ctrl dual_chan_port_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_push(a_push), .a_full(a_full),
  .seq_grant(seq_grant), .rd_req(rd_req), .o_valid(o_valid),
  .o_ready(o_ready), .o_hi_word(o_hi_word), .o_lo_word(o_lo_word),
  .o_lo_idle(o_lo_idle), .o_hi_src(o_hi_src), .o_lo_src(o_lo_src)
);

// File: tb/dual_chan_port_ctrl_bench.sv
module dual_chan_port_ctrl_bench;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 4;

  logic        clk = 0, rst_n = 0;
  logic        a_push = 0, b_push = 0, seq_grant = 0, o_ready = 0;
  logic [7:0]  a_addr = 0, b_addr = 0, rd_addr;
  logic [3:0]  fc_ingress = 0, fc_subport = 0;
  logic        a_full, b_full, rd_req, o_valid, o_lo_idle, o_hi_src, o_lo_src;
  logic        rd_rvalid = 0;
  logic [31:0] rd_rdata = 0, o_hi_word, o_lo_word;

  always #(CLK_NS/2) clk = ~clk;

  dual_chan_port_ctrl u_dual_chan_port_ctrl (.*);

  int vecs = 0, errs = 0;
  bit reported = 0;

  function automatic logic [31:0] memf(input logic [7:0] a);
    return {a, a ^ 8'hA5, ~a, a + 8'h3C};
  endfunction

  // memory model
  logic       pend = 0;
  logic [7:0] paddr = 0;
  int         lat = 0;
  logic [7:0] rlog[$];
  always @(posedge clk) begin
    rd_rvalid <= 1'b0;
    if (rd_req) begin
      pend  <= 1'b1;
      paddr <= rd_addr;
      lat   <= $urandom_range(0, 2);
      rlog.push_back(rd_addr);
    end else if (pend) begin
      if (lat == 0) begin
        rd_rvalid <= 1'b1;
        rd_rdata  <= memf(paddr);
        pend      <= 1'b0;
      end else lat <= lat - 1;
    end
  end

  // scoreboard state
  logic [7:0] ma[$], mb[$];
  bit         mlast = 1, busy = 0;
  logic [7:0] e_hi, e_lo;
  bit         e_hs, e_ls, e_lu;

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    report();
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit pick(input int na, input int nb, input bit last);
    if (na > 0 && nb > 0) return !last;
    return nb > 0;
  endfunction

  // one cycle starting just after a negedge
  task automatic cyc(input bit g, input bit pa, input logic [7:0] aa, input bit pb, input logic [7:0] ab);
    bit fa, fb, s1, s2;
    fa = (ma.size() == DEPTH);
    fb = (mb.size() == DEPTH);
    seq_grant = g; a_push = pa; a_addr = aa; b_push = pb; b_addr = ab;
    fc_ingress = 4'($urandom); fc_subport = 4'($urandom);
    if (g && !busy && (ma.size() + mb.size()) > 0) begin
      s1 = pick(ma.size(), mb.size(), mlast);
      e_hi = s1 ? mb.pop_front() : ma.pop_front();
      e_hs = s1; mlast = s1;
      e_lu = (ma.size() + mb.size()) > 0;
      e_ls = 0;
      if (e_lu) begin
        s2 = pick(ma.size(), mb.size(), mlast);
        e_lo = s2 ? mb.pop_front() : ma.pop_front();
        e_ls = s2; mlast = s2;
      end
      busy = 1;
      rlog.delete();
    end
    if (pa && !fa) ma.push_back(aa);
    if (pb && !fb) mb.push_back(ab);
    @(negedge clk);
    seq_grant = 0; a_push = 0; b_push = 0;
    chk(a_full == (ma.size() == DEPTH), "R8 a_full", a_full, ma.size() == DEPTH);
    chk(b_full == (mb.size() == DEPTH), "R8 b_full", b_full, mb.size() == DEPTH);
  endtask

  task automatic finish_tx(input bit noisy);
    int n;
    logic [7:0] gexp;
    logic [31:0] hw0, lw0;
    n = 0;
    while (!o_valid && n < 100) begin
      n++;
      if (noisy) cyc($urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0, 8'($urandom),
                     $urandom_range(0, 3) == 0, 8'($urandom));   // R9 stray grants
      else cyc(0, 0, 0, 0, 0);
    end
    if (!o_valid) begin
      errs++; vecs++;
      $display("FAIL R3: no output pair (actual 0 expected 1)");
      busy = 0;
      return;
    end
    gexp = {fc_ingress, fc_subport};
    chk(o_hi_src == e_hs, "R5 hi source", o_hi_src, e_hs);
    chk(o_hi_word == {memf(e_hi)[31:8], gexp}, "R6 hi word", o_hi_word, {memf(e_hi)[31:8], gexp});
    chk(o_lo_idle == !e_lu, "R4 lo idle", o_lo_idle, !e_lu);
    if (e_lu) begin
      chk(o_lo_src == e_ls, "R5 lo source", o_lo_src, e_ls);
      chk(o_lo_word == {memf(e_lo)[31:8], gexp}, "R3 lo word", o_lo_word, {memf(e_lo)[31:8], gexp});
      chk(rlog.size() == 2 && rlog[0] == e_hi && rlog[1] == e_lo, "R10 read order",
          rlog.size() == 2 ? {rlog[0], rlog[1]} : 16'hFFFF, {e_hi, e_lo});
    end else begin
      chk(o_lo_word == 0, "R4 lo word", o_lo_word, 0);
      chk(rlog.size() == 1 && rlog[0] == e_hi, "R4 single read",
          rlog.size() == 1 ? rlog[0] : 8'hFF, e_hi);
    end
    hw0 = o_hi_word; lw0 = o_lo_word;
    repeat ($urandom_range(0, 3)) begin
      fc_ingress = 4'($urandom); fc_subport = 4'($urandom);
      @(negedge clk);
      chk(o_valid && o_hi_word == hw0 && o_lo_word == lw0, "R7 hold", o_hi_word, hw0);
    end
    o_ready = 1;
    @(negedge clk);
    o_ready = 0;
    busy = 0;
    chk(!o_valid, "R7 accepted", o_valid, 0);
  endtask

  task automatic grant_pair(input bit noisy);
    cyc(1, 0, 0, 0, 0);
    if (busy) finish_tx(noisy);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(!o_valid && !rd_req && !a_full && !b_full, "R1 in reset", {o_valid, rd_req, a_full, b_full}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!o_valid && !rd_req && !a_full && !b_full, "R1 after reset", {o_valid, rd_req, a_full, b_full}, 0);

    // R2 grant with nothing pending
    cyc(1, 0, 0, 0, 0);
    rlog.delete();
    repeat (5) @(negedge clk);
    chk(!o_valid && rlog.size() == 0, "R2 empty grant", {o_valid, 8'(rlog.size())}, 0);

    // R4 single address on A, then on B
    cyc(0, 1, 8'h11, 0, 0);
    grant_pair(0);
    cyc(0, 0, 0, 1, 8'h22);
    grant_pair(0);

    // R5 tie order: fill both queues, alternate over grants
    for (int i = 0; i < DEPTH; i++) cyc(0, 1, 8'h40 + 8'(i), 1, 8'h80 + 8'(i));
    cyc(0, 1, 8'hEE, 1, 8'hEF);       // R8 dropped pushes
    for (int i = 0; i < DEPTH; i++) grant_pair(1);

    // R3 two from one source
    cyc(0, 1, 8'h31, 0, 0);
    cyc(0, 1, 8'h32, 0, 0);
    grant_pair(0);

    // grant coinciding with pushes on a full queue and the other queue
    for (int i = 0; i < DEPTH; i++) cyc(0, 1, 8'h60 + 8'(i), 0, 0);
    cyc(1, 1, 8'h6F, 1, 8'h70);
    if (busy) finish_tx(0);
    while (ma.size() + mb.size() > 0) grant_pair(0);

    // random phase
    for (int t = 0; t < 200; t++) begin
      repeat ($urandom_range(0, 3))
        cyc(0, $urandom_range(0, 1) == 1, 8'($urandom), $urandom_range(0, 1) == 1, 8'($urandom));
      cyc(1, $urandom_range(0, 2) == 0, 8'($urandom), $urandom_range(0, 2) == 0, 8'($urandom));
      if (busy) finish_tx(1);
      else begin
        @(negedge clk);
        chk(!o_valid, "R2 idle grant", o_valid, 0);
      end
    end
    report();
  end
endmodule